// File: doc/BRIEF.md
# Decoupled Two-Stage Mesh Router

This block is one switching node of a two-dimensional mesh network-on-chip. It takes single-flit packets on five links (north, south, east, west and the attached core) and forwards each flit one hop closer to the destination coordinates carried in the flit. Routing is dimension-ordered: a flit first travels along X until its column matches, and only then along Y.

Switching is split into two decoupled stages instead of one full five-by-five crossbar. The first stage looks at the head flit of each input queue and sorts it into the row group (east or west), the column group (north or south) or local delivery. The second stage holds one round-robin arbiter per group output. The row group drives only the east, west and local outputs; the column group drives only the north, south and local outputs. The local output is shared by both groups under a fixed order.

The node is placed with its own coordinates and the mesh size as parameters. Ports that face outside the mesh are never driven, and a flit whose route would leave the mesh is handed to the local core. Every link uses a valid/ready handshake, each input has a small queue, and every output is a register.

Top module: `mesh_router`

## Requirements
- R1: Port index 0 is north, 1 is south, 2 is east, 3 is west, 4 is local; a flit is {dest_x[COORD_W], dest_y[COORD_W], payload[PAYLOAD_W]} from the most significant bit down, and it leaves the router unchanged, exactly once, on the port chosen by R2/R3.
- R2: With dest_x above the node's X the flit goes east, below goes west; with equal X, dest_y above goes north, below goes south; with both equal it goes local.
- R3: A port on the mesh boundary (east at X = MESH_X-1, west at X = 0, north at Y = MESH_Y-1, south at Y = 0) never raises out_valid; a flit whose R2 direction is such a port is delivered to local.
- R4: Each input queue holds FIFO_DEPTH (4) flits; in_ready is low exactly while the queue is full, and a flit is taken only when in_valid and in_ready are high at the same edge.
- R5: While out_valid is high and out_ready is low, out_valid and out_flit stay unchanged; a new flit is loaded into an output only when it is empty or being taken at that edge.
- R6: North, south, east and west outputs each pick among requesting inputs in round-robin order starting at the input after the last winner; the pointer moves only on a granted transfer.
- R7: Local requests from north/south inputs form the column unit, from east/west/local inputs the row unit; each unit is round-robin, and the column unit wins the local output whenever it has a request.
- R8: A flit accepted at an edge can be granted at the next edge, so out_valid rises one cycle after acceptance.
- R9: During and after reset all in_ready are high, all out_valid are low and every round-robin pointer starts at input 0.
- R10: Flits from one input leave in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 5 | Per-input flit valid |
| in_ready | output | 5 | Per-input queue not full |
| in_flit | input | 5*FLIT_W | Input flits, port i at bits i*FLIT_W upward |
| out_valid | output | 5 | Per-output registered flit valid |
| out_ready | input | 5 | Per-output downstream ready |
| out_flit | output | 5*FLIT_W | Output flits, port i at bits i*FLIT_W upward |

## Verification
The hardest state to reach is several queues full at once with their heads competing for one output while that output's ready toggles, because only then do round-robin pointer advances and the local fixed order show up. The stimulus first fills every queue with output ready held low, then releases ready randomly while all inputs aim at the west or local port, and a behavioural reference model predicts every in_ready, out_valid and out_flit on every cycle. An east-edge node position is used so that off-mesh destinations and the unused east port can be exercised.

// File: rtl/mesh_router_pkg.sv
package mesh_router_pkg;
  localparam int NUM_PORTS = 5;
  localparam int NUM_DIRS  = 4;
  localparam int PORT_N = 0;
  localparam int PORT_S = 1;
  localparam int PORT_E = 2;
  localparam int PORT_W = 3;
  localparam int PORT_L = 4;
  localparam int IDX_W  = 3;

  typedef logic [IDX_W-1:0] port_idx_t;

  // local-output group membership by input index
  localparam logic [NUM_PORTS-1:0] ROW_MEMBERS = 5'b11100;
  localparam logic [NUM_PORTS-1:0] COL_MEMBERS = 5'b00011;

  function automatic port_idx_t next_idx(port_idx_t i);
    return (i == port_idx_t'(NUM_PORTS-1)) ? '0 : i + 1'b1;
  endfunction
endpackage

// File: rtl/router_in_fifo.sv
module router_in_fifo #(
  parameter int WIDTH = 14,
  parameter int DEPTH = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int CNTW = $clog2(DEPTH+1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_valid,
  output logic             push_ready,
  input  logic [WIDTH-1:0] push_data,
  output logic             head_valid,
  output logic [WIDTH-1:0] head_data,
  input  logic             pop
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CNTW-1:0]  count;
  logic             push_fire;

  function automatic logic [AW-1:0] wrap_inc(logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign push_ready = (count != CNTW'(DEPTH));
  assign head_valid = (count != '0);
  assign head_data  = mem[rd_ptr];
  assign push_fire  = push_valid && push_ready;

  // storage without reset so it can map onto RAM
  always_ff @(posedge clk) begin
    if (push_fire) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_fire) wr_ptr <= wrap_inc(wr_ptr);
      if (pop)       rd_ptr <= wrap_inc(rd_ptr);
      case ({push_fire, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R4
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
    pop |-> head_valid);
  // R4
  fifo_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CNTW'(DEPTH));
endmodule

// File: rtl/mesh_route_calc.sv
module mesh_route_calc import mesh_router_pkg::*; #(
  parameter int MESH_X  = 8,
  parameter int MESH_Y  = 8,
  parameter int NODE_X  = 3,
  parameter int NODE_Y  = 3,
  parameter int COORD_W = 3
) (
  input  logic [COORD_W-1:0] dest_x,
  input  logic [COORD_W-1:0] dest_y,
  output port_idx_t          out_dir
);
  localparam bit HAS_E = (NODE_X < MESH_X-1);
  localparam bit HAS_W = (NODE_X > 0);
  localparam bit HAS_N = (NODE_Y < MESH_Y-1);
  localparam bit HAS_S = (NODE_Y > 0);
  localparam logic [COORD_W-1:0] HERE_X = COORD_W'(NODE_X);
  localparam logic [COORD_W-1:0] HERE_Y = COORD_W'(NODE_Y);

  // X first, then Y; an off-mesh hop falls back to local delivery
  always_comb begin
    if (dest_x > HERE_X)
      out_dir = HAS_E ? port_idx_t'(PORT_E) : port_idx_t'(PORT_L);
    else if (dest_x < HERE_X)
      out_dir = HAS_W ? port_idx_t'(PORT_W) : port_idx_t'(PORT_L);
    else if (dest_y > HERE_Y)
      out_dir = HAS_N ? port_idx_t'(PORT_N) : port_idx_t'(PORT_L);
    else if (dest_y < HERE_Y)
      out_dir = HAS_S ? port_idx_t'(PORT_S) : port_idx_t'(PORT_L);
    else
      out_dir = port_idx_t'(PORT_L);
  end
endmodule

// File: rtl/router_rr_pick.sv
module router_rr_pick import mesh_router_pkg::*; #(
  parameter int N = 5
) (
  input  logic [N-1:0] req,
  input  port_idx_t    ptr,
  output logic         any,
  output logic [N-1:0] gnt,
  output port_idx_t    idx
);
  function automatic int rot(port_idx_t base, int k);
    return (int'(base) + k) % N;
  endfunction

  always_comb begin
    any = 1'b0;
    gnt = '0;
    idx = '0;
    for (int k = 0; k < N; k++) begin
      if (!any && req[rot(ptr, k)]) begin
        any = 1'b1;
        gnt[rot(ptr, k)] = 1'b1;
        idx = port_idx_t'(rot(ptr, k));
      end
    end
  end
endmodule

// File: rtl/mesh_router.sv
module mesh_router import mesh_router_pkg::*; #(
  parameter int MESH_X     = 8,
  parameter int MESH_Y     = 8,
  parameter int NODE_X     = 3,
  parameter int NODE_Y     = 3,
  parameter int COORD_W    = 3,
  parameter int PAYLOAD_W  = 8,
  parameter int FIFO_DEPTH = 4,
  localparam int FLIT_W = 2*COORD_W + PAYLOAD_W
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_PORTS-1:0]        in_valid,
  output logic [NUM_PORTS-1:0]        in_ready,
  input  logic [NUM_PORTS*FLIT_W-1:0] in_flit,
  output logic [NUM_PORTS-1:0]        out_valid,
  input  logic [NUM_PORTS-1:0]        out_ready,
  output logic [NUM_PORTS*FLIT_W-1:0] out_flit
);
  logic [FLIT_W-1:0]    head [NUM_PORTS];
  logic [NUM_PORTS-1:0] head_ok;
  logic [NUM_PORTS-1:0] pop;
  port_idx_t            dir  [NUM_PORTS];
  logic [NUM_PORTS-1:0] req  [NUM_PORTS];   // req[output][input]
  logic [NUM_PORTS-1:0] grant[NUM_PORTS];   // grant[output][input]
  logic [FLIT_W-1:0]    sel_flit [NUM_PORTS];
  logic [NUM_PORTS-1:0] out_free;

  logic [NUM_PORTS-1:0] pick_gnt [NUM_DIRS];
  port_idx_t            pick_idx [NUM_DIRS];
  logic [NUM_DIRS-1:0]  pick_any;
  port_idx_t            ptr      [NUM_DIRS];

  logic [NUM_PORTS-1:0] row_gnt, col_gnt;
  port_idx_t            row_idx, col_idx, ptr_row, ptr_col;
  logic                 row_any, col_any;

  // stage 1: queue and classify each input
  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_in
    router_in_fifo #(.WIDTH(FLIT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk        (clk),
      .rst        (rst),
      .push_valid (in_valid[i]),
      .push_ready (in_ready[i]),
      .push_data  (in_flit[i*FLIT_W +: FLIT_W]),
      .head_valid (head_ok[i]),
      .head_data  (head[i]),
      .pop        (pop[i])
    );
    mesh_route_calc #(
      .MESH_X(MESH_X), .MESH_Y(MESH_Y), .NODE_X(NODE_X), .NODE_Y(NODE_Y),
      .COORD_W(COORD_W)
    ) u_route (
      .dest_x  (head[i][FLIT_W-1 -: COORD_W]),
      .dest_y  (head[i][FLIT_W-COORD_W-1 -: COORD_W]),
      .out_dir (dir[i])
    );
  end

  always_comb begin
    for (int o = 0; o < NUM_PORTS; o++)
      for (int i = 0; i < NUM_PORTS; i++)
        req[o][i] = head_ok[i] && (dir[i] == port_idx_t'(o));
  end

  // stage 2: row/column group arbiters for the four mesh outputs
  for (genvar o = 0; o < NUM_DIRS; o++) begin : g_dir
    router_rr_pick #(.N(NUM_PORTS)) u_pick (
      .req (req[o]),
      .ptr (ptr[o]),
      .any (pick_any[o]),
      .gnt (pick_gnt[o]),
      .idx (pick_idx[o])
    );
  end

  // shared local output: one unit per group
  router_rr_pick #(.N(NUM_PORTS)) u_pick_row (
    .req (req[PORT_L] & ROW_MEMBERS),
    .ptr (ptr_row),
    .any (row_any),
    .gnt (row_gnt),
    .idx (row_idx)
  );
  router_rr_pick #(.N(NUM_PORTS)) u_pick_col (
    .req (req[PORT_L] & COL_MEMBERS),
    .ptr (ptr_col),
    .any (col_any),
    .gnt (col_gnt),
    .idx (col_idx)
  );

  always_comb begin
    out_free = ~out_valid | out_ready;
    for (int o = 0; o < NUM_DIRS; o++)
      grant[o] = (out_free[o] && pick_any[o]) ? pick_gnt[o] : '0;
    if (!out_free[PORT_L])
      grant[PORT_L] = '0;
    else
      grant[PORT_L] = col_any ? col_gnt : row_gnt;

    pop = '0;
    for (int o = 0; o < NUM_PORTS; o++)
      pop = pop | grant[o];

    for (int o = 0; o < NUM_PORTS; o++) begin
      sel_flit[o] = '0;
      for (int i = 0; i < NUM_PORTS; i++)
        if (grant[o][i]) sel_flit[o] = head[i];
    end
  end

  // output registers and arbiter pointers
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= '0;
      for (int o = 0; o < NUM_DIRS; o++) ptr[o] <= '0;
      ptr_row <= '0;
      ptr_col <= '0;
    end else begin
      for (int o = 0; o < NUM_PORTS; o++) begin
        if (|grant[o]) begin
          out_valid[o] <= 1'b1;
          out_flit[o*FLIT_W +: FLIT_W] <= sel_flit[o];
        end else if (out_ready[o]) begin
          out_valid[o] <= 1'b0;
        end
      end
      for (int o = 0; o < NUM_DIRS; o++)
        if (|grant[o]) ptr[o] <= next_idx(pick_idx[o]);
      if (|grant[PORT_L]) begin
        if (col_any) ptr_col <= next_idx(col_idx);
        else         ptr_row <= next_idx(row_idx);
      end
    end
  end

  for (genvar o = 0; o < NUM_PORTS; o++) begin : g_chk
    // R5
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid[o] && !out_ready[o] |=>
        out_valid[o] && $stable(out_flit[o*FLIT_W +: FLIT_W]));
    // R1
    grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(grant[o]));
  end

  for (genvar o = 0; o < NUM_DIRS; o++) begin : g_ptr_chk
    // R6
    ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !(|grant[o]) |=> $stable(ptr[o]));
  end

  // R7
  local_order_chk: assert property (@(posedge clk) disable iff (rst)
    (|(req[PORT_L] & COL_MEMBERS)) && out_free[PORT_L] |->
      ((grant[PORT_L] & ROW_MEMBERS) == '0));

  if (NODE_X == MESH_X-1) begin : g_edge_e
    // R3
    east_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !out_valid[PORT_E]);
  end
  if (NODE_X == 0) begin : g_edge_w
    // R3
    west_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !out_valid[PORT_W]);
  end
  if (NODE_Y == MESH_Y-1) begin : g_edge_n
    // R3
    north_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !out_valid[PORT_N]);
  end
  if (NODE_Y == 0) begin : g_edge_s
    // R3
    south_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !out_valid[PORT_S]);
  end
endmodule

// File: tb/mesh_router_tb.sv
`timescale 1ns/1ps
module mesh_router_tb;
  import mesh_router_pkg::*;

  localparam int MX = 6, MY = 6, NX = 5, NY = 2;
  localparam int CW = 3, PLW = 8, DEP = 4;
  localparam int FW = 2*CW + PLW;
  localparam int NP = NUM_PORTS;
  localparam logic [NP-1:0] DRIVEN = 5'b11011;  // east input faces off-mesh

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NP-1:0]    in_valid, in_ready, out_valid, out_ready;
  logic [NP*FW-1:0] in_flit, out_flit;

  always #2 clk = ~clk;

  mesh_router #(
    .MESH_X(MX), .MESH_Y(MY), .NODE_X(NX), .NODE_Y(NY),
    .COORD_W(CW), .PAYLOAD_W(PLW), .FIFO_DEPTH(DEP)
  ) u_dut (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_flit(in_flit),
    .out_valid(out_valid), .out_ready(out_ready), .out_flit(out_flit)
  );

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [7:0] seq = 8'd0;
  int sweep = 0;

  // reference model state
  logic [FW-1:0] mq [NP][DEP];
  int            mcnt [NP];
  logic          mov  [NP];
  logic [FW-1:0] mof  [NP];
  int            mptr [NUM_DIRS];
  int            mrow, mcol;

  function automatic int route_of(logic [FW-1:0] f);
    int dx, dy;
    dx = int'(f[FW-1 -: CW]);
    dy = int'(f[FW-1-CW -: CW]);
    if (dx > NX) return (NX < MX-1) ? PORT_E : PORT_L;
    if (dx < NX) return (NX > 0) ? PORT_W : PORT_L;
    if (dy > NY) return (NY < MY-1) ? PORT_N : PORT_L;
    if (dy < NY) return (NY > 0) ? PORT_S : PORT_L;
    return PORT_L;
  endfunction

  function automatic int pick(logic [NP-1:0] rq, int p);
    for (int k = 0; k < NP; k++) begin
      int j;
      j = (p + k) % NP;
      if (rq[j]) return j;
    end
    return -1;
  endfunction

  function automatic logic [FW-1:0] mk(int x, int y, logic [7:0] pl);
    logic [CW-1:0] xs, ys;
    xs = CW'(x);
    ys = CW'(y);
    return {xs, ys, pl};
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NP; i++) begin
      mcnt[i] = 0;
      mov[i] = 1'b0;
      mof[i] = '0;
    end
    for (int o = 0; o < NUM_DIRS; o++) mptr[o] = 0;
    mrow = 0;
    mcol = 0;
  endtask

  task automatic model_update();
    int   dirv [NP];
    bit   rdy  [NP];
    bit   fr   [NP];
    int   win  [NP];
    logic [NP-1:0] rq, rcol, rrow;
    int   w, wc, wr;
    for (int i = 0; i < NP; i++) begin
      dirv[i] = (mcnt[i] > 0) ? route_of(mq[i][0]) : -1;
      rdy[i]  = (mcnt[i] < DEP);
    end
    for (int o = 0; o < NP; o++) begin
      fr[o]  = !mov[o] || out_ready[o];
      win[o] = -1;
    end
    for (int o = 0; o < NUM_DIRS; o++) begin
      for (int i = 0; i < NP; i++) rq[i] = (dirv[i] == o);
      if (fr[o]) begin
        w = pick(rq, mptr[o]);
        if (w >= 0) begin
          win[o] = w;
          mptr[o] = (w + 1) % NP;
        end
      end
    end
    for (int i = 0; i < NP; i++) begin
      rcol[i] = (dirv[i] == PORT_L) && (i == PORT_N || i == PORT_S);
      rrow[i] = (dirv[i] == PORT_L) && !(i == PORT_N || i == PORT_S);
    end
    if (fr[PORT_L]) begin
      wc = pick(rcol, mcol);
      wr = pick(rrow, mrow);
      if (wc >= 0) begin
        win[PORT_L] = wc;
        mcol = (wc + 1) % NP;
      end else if (wr >= 0) begin
        win[PORT_L] = wr;
        mrow = (wr + 1) % NP;
      end
    end
    for (int o = 0; o < NP; o++) begin
      if (win[o] >= 0) begin
        mov[o] = 1'b1;
        mof[o] = mq[win[o]][0];
      end else if (out_ready[o]) begin
        mov[o] = 1'b0;
      end
    end
    for (int o = 0; o < NP; o++) begin
      if (win[o] >= 0) begin
        for (int k = 0; k < DEP-1; k++) mq[win[o]][k] = mq[win[o]][k+1];
        mcnt[win[o]] = mcnt[win[o]] - 1;
      end
    end
    for (int i = 0; i < NP; i++) begin
      if (in_valid[i] && rdy[i]) begin
        mq[i][mcnt[i]] = in_flit[i*FW +: FW];
        mcnt[i] = mcnt[i] + 1;
      end
    end
  endtask

  task automatic check_bit(string tag, string what, int idx, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s[%0d] actual=%0b expected=%0b", tag, what, idx, act, exp);
    end
  endtask

  task automatic check_flit(string tag, int idx, logic [FW-1:0] act, logic [FW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s out_flit[%0d] actual=%h expected=%h", tag, idx, act, exp);
    end
  endtask

  task automatic compare(string tag);
    for (int i = 0; i < NP; i++) begin
      check_bit(tag, "in_ready", i, in_ready[i], mcnt[i] < DEP);
      check_bit(tag, "out_valid", i, out_valid[i], mov[i]);
      if (mov[i]) check_flit(tag, i, out_flit[i*FW +: FW], mof[i]);
    end
  endtask

  task automatic gen(int mode);
    in_valid = '0;
    in_flit  = '0;
    out_ready = '1;
    for (int i = 0; i < NP; i++) begin
      int x, y;
      seq = seq + 8'd1;
      x = $urandom % 8;
      y = $urandom % 8;
      case (mode)
        0: if (i == PORT_L) begin        // R2 sweep of in-mesh targets
             in_valid[i] = 1'b1;
             x = sweep % MX;
             y = (sweep / MX) % MY;
             sweep++;
           end
        1: if (i == PORT_L || i == PORT_W) begin   // R3 off-mesh X
             in_valid[i] = 1'b1;
             x = MX + ($urandom % 2);
           end
        2: begin                          // R4 fill with outputs stalled
             in_valid[i] = DRIVEN[i];
             x = $urandom % MX;
             y = $urandom % MY;
             out_ready = '0;
           end
        3: begin                          // R5 random backpressure
             in_valid[i] = DRIVEN[i] && ($urandom % 2 == 0);
             x = $urandom % MX;
             y = $urandom % MY;
             out_ready[i] = ($urandom % 2 == 0);
           end
        4: begin                          // R6 everyone heads west
             in_valid[i] = DRIVEN[i];
             x = $urandom % NX;
             out_ready[i] = ($urandom % 10 < 7);
           end
        5: begin                          // R7 everyone heads local
             in_valid[i] = DRIVEN[i];
             x = NX;
             y = NY;
             out_ready[i] = ($urandom % 10 < 6);
           end
        6: begin                          // R1/R10 mixed traffic
             in_valid[i] = DRIVEN[i] && ($urandom % 3 != 0);
             out_ready[i] = ($urandom % 4 != 0);
           end
        8: if (i == PORT_N) begin         // R8 one flit to local
             in_valid[i] = 1'b1;
             x = NX;
             y = NY;
           end
        default: ;                        // drain
      endcase
      in_flit[i*FW +: FW] = mk(x, y, seq);
    end
  endtask

  task automatic step(string tag);
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic run(string tag, int mode, int n);
    repeat (n) begin
      gen(mode);
      step(tag);
    end
  endtask

  initial begin
    in_valid = '0;
    in_flit = '0;
    out_ready = '0;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    // R9 reset state
    for (int i = 0; i < NP; i++) begin
      check_bit("R9", "in_ready", i, in_ready[i], 1'b1);
      check_bit("R9", "out_valid", i, out_valid[i], 1'b0);
    end
    run("R2", 0, 80);
    run("R2", 7, 6);
    run("R3", 1, 40);
    run("R3", 7, 10);
    run("R4", 2, 12);
    // R4 every driven queue is full now
    for (int i = 0; i < NP; i++)
      if (DRIVEN[i]) check_bit("R4", "in_ready_full", i, in_ready[i], 1'b0);
    run("R5", 3, 150);
    run("R6", 4, 200);
    run("R5", 7, 20);
    run("R7", 5, 200);
    run("R7", 7, 20);
    // R8 one-cycle hop
    gen(8);
    step("R8");
    check_bit("R8", "out_valid_early", PORT_L, out_valid[PORT_L], 1'b0);
    gen(7);
    step("R8");
    check_bit("R8", "out_valid_next", PORT_L, out_valid[PORT_L], 1'b1);
    gen(7);
    step("R8");
    check_bit("R8", "out_valid_after", PORT_L, out_valid[PORT_L], 1'b0);
    run("R10", 6, 1500);
    run("R1", 7, 20);
    for (int i = 0; i < NP; i++)
      check_bit("R1", "drained", i, out_valid[i], 1'b0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule